// File: doc/BRIEF.md
# Power-Stage Bring-Up and Output Short-Check Sequencer

This block controls how a four-output PWM power stage is brought up and taken down. It watches two supply-good flags, one for the gate drive and one for the logic supply, and an active-low amplifier reset. The analog ramp, the short-sense comparators and the gate drivers are outside the block. Each of them appears here as a digital flag or enable, and the block advances through its steps on a millisecond tick.

After the supplies report good, the block runs a short test on the output pins. The test has two phases: a check for outputs stuck low, then a check for outputs stuck high. Each phase waits a programmable number of ticks before it reads the sense flags. A failing phase stalls until the fault clears, and the sequence then continues. The test runs only once. When it has passed and the amplifier reset is high, a soft-start ramp runs for a fixed 100 ticks plus a programmable extra. Once the ramp ends, the stage is marked running. Pulling the reset low while running starts a shutdown ramp of the same length, and the outputs return to Hi-Z when it ends. If a supply flag drops, the block returns at once to the all-Hi-Z wait state.

Top module: `amp_bringup_seq`

## Requirements
- R1: Every bit of `out_hiz` is 1 in the same cycle that `gvdd_ok` or `vdd_ok` is 0, and also in every state other than ramping up, running or ramping down.
- R2: `weak_pd` is 1 exactly when `amp_rst_n` is 0 and the outputs are Hi-Z, so that it never overlaps switching.
- R3: The short test starts with the stuck-low phase and then runs the stuck-high phase. Each phase waits `settle_ticks` ticks of `ms_tick` before it samples its sense vector. The outputs stay Hi-Z for the whole test.
- R4: If a phase reads any set bit in its sense vector (`short_lo` for the first phase, `short_hi` for the second), the block stays in that phase and keeps sampling. It moves on in the first cycle that the vector reads all zeros.
- R5: The short test runs once after logic reset. After it has passed, short-sense inputs have no effect, and a supply dip followed by recovery goes directly to waiting for the amplifier reset.
- R6: With the test passed and `amp_rst_n` high, the start-up ramp begins. `ramp_active` stays 1 for exactly `FIXED_MS + ramp_extra` ticks, counted with the extra value captured at the start of the ramp.
- R7: `running` rises in the cycle after the last ramp tick. `amp_rst_n` low while running starts a shutdown ramp of the same tick length, and the outputs go Hi-Z when that ramp ends.
- R8: A supply-good flag at 0 sends the block to the wait state on the next clock edge from any state. `ramp_active` and `running` drop to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low logic reset |
| gvdd_ok | input | 1 | Gate-drive supply above its undervoltage threshold |
| vdd_ok | input | 1 | Logic supply above its undervoltage threshold |
| amp_rst_n | input | 1 | Active-low amplifier reset / run request |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ramp_extra | input | XW | Extra ramp length in ticks, added to FIXED_MS |
| settle_ticks | input | SW | Settle ticks before each short-test phase samples |
| short_lo | input | N_OUT | Per-output stuck-low sense flags |
| short_hi | input | N_OUT | Per-output stuck-high sense flags |
| out_hiz | output | N_OUT | Per-output Hi-Z enable (1 = Hi-Z) |
| weak_pd | output | 1 | Weak output pulldown enable for bootstrap charging |
| ramp_active | output | 1 | A start-up or shutdown ramp is in progress |
| running | output | 1 | Start-up has finished and the stage is switching normally |

## Verification
A wrong state shows up at the ports as a change in the timing of `ramp_active` and `running`. The Hi-Z outputs release too early or too late, or a ramp lasts one tick too long or too short. A faulty ramp counter shows at the edge where the ramp should end, at most one tick away. A wrong short-test phase or done flag shows as a ramp that starts while a stuck-low or stuck-high flag is set, or as a settle delay that is skipped or repeated after a supply dip. A behavioural model runs in step with the design and is compared every cycle, so each fault is reported in the cycle it first reaches a port.

// File: rtl/amp_bringup_seq.sv
module amp_bringup_seq #(
  parameter int N_OUT    = 4,
  parameter int XW       = 11,
  parameter int SW       = 4,
  parameter int FIXED_MS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gvdd_ok,
  input  logic             vdd_ok,
  input  logic             amp_rst_n,
  input  logic             ms_tick,
  input  logic [XW-1:0]    ramp_extra,
  input  logic [SW-1:0]    settle_ticks,
  input  logic [N_OUT-1:0] short_lo,
  input  logic [N_OUT-1:0] short_hi,
  output logic [N_OUT-1:0] out_hiz,
  output logic             weak_pd,
  output logic             ramp_active,
  output logic             running
);
  localparam int LW = $clog2(FIXED_MS + (1 << XW)) + 1;

  typedef enum logic [2:0] {
    S_WAIT, S_CHK_LO, S_CHK_HI, S_IDLE, S_UP, S_RUN, S_DOWN
  } state_t;

  state_t        state;
  logic [SW-1:0] settle_cnt;
  logic [LW-1:0] ramp_cnt;
  logic [LW-1:0] ramp_last;
  logic          test_done;

  logic sup_ok, driving, settled, tick_end;

  assign sup_ok   = gvdd_ok & vdd_ok;
  assign driving  = sup_ok & (state == S_UP || state == S_RUN || state == S_DOWN);
  assign settled  = (settle_cnt == settle_ticks);
  assign tick_end = ms_tick & (ramp_cnt == ramp_last);

  assign out_hiz     = {N_OUT{~driving}};
  assign weak_pd     = ~amp_rst_n & ~driving;
  assign ramp_active = sup_ok & (state == S_UP || state == S_DOWN);
  assign running     = sup_ok & (state == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_WAIT;
      settle_cnt <= '0;
      ramp_cnt   <= '0;
      ramp_last  <= '0;
      test_done  <= 1'b0;
    end else if (!sup_ok) begin
      state      <= S_WAIT;
      settle_cnt <= '0;
      ramp_cnt   <= '0;
    end else begin
      case (state)
        S_WAIT: begin
          settle_cnt <= '0;
          state      <= test_done ? S_IDLE : S_CHK_LO;
        end
        S_CHK_LO: begin
          if (settled) begin
            if (short_lo == '0) begin
              state      <= S_CHK_HI;
              settle_cnt <= '0;
            end
          end else if (ms_tick) begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        S_CHK_HI: begin
          if (settled) begin
            if (short_hi == '0) begin
              state     <= S_IDLE;
              test_done <= 1'b1;
            end
          end else if (ms_tick) begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (amp_rst_n) begin
            state     <= S_UP;
            ramp_cnt  <= '0;
            ramp_last <= LW'(FIXED_MS - 1) + LW'(ramp_extra);
          end
        end
        S_UP: begin
          if (tick_end)     state    <= S_RUN;
          else if (ms_tick) ramp_cnt <= ramp_cnt + 1'b1;
        end
        S_RUN: begin
          if (!amp_rst_n) begin
            state     <= S_DOWN;
            ramp_cnt  <= '0;
            ramp_last <= LW'(FIXED_MS - 1) + LW'(ramp_extra);
          end
        end
        S_DOWN: begin
          if (tick_end)     state    <= S_IDLE;
          else if (ms_tick) ramp_cnt <= ramp_cnt + 1'b1;
        end
        default: state <= S_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/amp_bringup_seq_chk.sv
module amp_bringup_seq_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gvdd_ok,
  input logic             vdd_ok,
  input logic             amp_rst_n,
  input logic             ms_tick,
  input logic [N_OUT-1:0] out_hiz,
  input logic             weak_pd,
  input logic             ramp_active,
  input logic             running,
  input logic             test_done
);
  logic sup_ok;
  assign sup_ok = gvdd_ok & vdd_ok;

  a_r1_hiz_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |-> (&out_hiz));

  a_r2_pulldown_only_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    weak_pd |-> ((&out_hiz) && !amp_rst_n));

  a_r3_hiz_until_tested: assert property (@(posedge clk) disable iff (!rst_n)
    !test_done |-> ((&out_hiz) && !ramp_active && !running));

  a_r6_ramp_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok && $past(sup_ok) && $fell(ramp_active)) |-> $past(ms_tick));

  a_r7_run_follows_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(ramp_active));

  a_r8_supply_loss_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> !(ramp_active && $past(ramp_active)) && !(running && $past(running)));
endmodule

bind amp_bringup_seq amp_bringup_seq_chk #(.N_OUT(N_OUT)) i_chk (
  .clk(clk), .rst_n(rst_n), .gvdd_ok(gvdd_ok), .vdd_ok(vdd_ok),
  .amp_rst_n(amp_rst_n), .ms_tick(ms_tick), .out_hiz(out_hiz),
  .weak_pd(weak_pd), .ramp_active(ramp_active), .running(running),
  .test_done(test_done)
);

// File: tb/test_amp_bringup_seq.sv
module test_amp_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_OUT = 4, XW = 11, SW = 4, FIXED_MS = 100;
  localparam int TICK_DIV = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rst_n = 0, gvdd_ok = 0, vdd_ok = 0, amp_rst_n = 0, ms_tick = 0;
  logic [XW-1:0] ramp_extra = '0;
  logic [SW-1:0] settle_ticks = '0;
  logic [N_OUT-1:0] short_lo = '0, short_hi = '0;
  logic [N_OUT-1:0] out_hiz;
  logic weak_pd, ramp_active, running;

  int checks = 0, failures = 0, tick_div = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_bringup_seq #(.N_OUT(N_OUT), .XW(XW), .SW(SW), .FIXED_MS(FIXED_MS)) i_amp_bringup_seq (
    .clk(clk), .rst_n(rst_n), .gvdd_ok(gvdd_ok), .vdd_ok(vdd_ok),
    .amp_rst_n(amp_rst_n), .ms_tick(ms_tick), .ramp_extra(ramp_extra),
    .settle_ticks(settle_ticks), .short_lo(short_lo), .short_hi(short_hi),
    .out_hiz(out_hiz), .weak_pd(weak_pd), .ramp_active(ramp_active), .running(running)
  );

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % TICK_DIV;
    ms_tick <= (tick_div == 0);
  end

  // Reference model: phase 0 wait, 1 low test, 2 high test, 3 idle, 4 up, 5 run, 6 down
  int m_phase = 0, m_settle = 0, m_ramp = 0, m_len = 0;
  bit m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_settle = 0; m_ramp = 0; m_done = 0;
    end else if (!(gvdd_ok && vdd_ok)) begin
      m_phase = 0; m_settle = 0; m_ramp = 0;
    end else begin
      case (m_phase)
        0: begin m_settle = 0; m_phase = m_done ? 3 : 1; end
        1, 2: begin
          if (m_settle == int'(settle_ticks)) begin
            if (m_phase == 1 && short_lo == 0) begin m_phase = 2; m_settle = 0; end
            else if (m_phase == 2 && short_hi == 0) begin m_phase = 3; m_done = 1; end
          end else if (ms_tick) m_settle++;
        end
        3: if (amp_rst_n) begin m_phase = 4; m_ramp = 0; m_len = FIXED_MS + int'(ramp_extra); end
        4, 6: if (ms_tick) begin
          m_ramp++;
          if (m_ramp == m_len) m_phase = (m_phase == 4) ? 5 : 3;
        end
        5: if (!amp_rst_n) begin m_phase = 6; m_ramp = 0; m_len = FIXED_MS + int'(ramp_extra); end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !finished) begin
      automatic bit sup = gvdd_ok && vdd_ok;
      automatic bit drv = sup && (m_phase >= 4);
      check("R1 out_hiz", 32'(out_hiz), drv ? 32'h0 : 32'hF);
      check("R2 weak_pd", 32'(weak_pd), 32'(!amp_rst_n && !drv));
      check("R6 ramp_active", 32'(ramp_active), 32'(sup && (m_phase == 4 || m_phase == 6)));
      check("R7 running", 32'(running), 32'(sup && m_phase == 5));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    ramp_extra = 11'd5; settle_ticks = 4'd2;
    cyc(5);
    check("R1 reset hiz", 32'(out_hiz), 32'hF);
    check("R2 reset pulldown", 32'(weak_pd), 32'h1);
    rst_n = 1; cyc(10);
    check("R1 no supply hiz", 32'(out_hiz), 32'hF);
    short_lo = 4'b0100; gvdd_ok = 1; vdd_ok = 1; cyc(30);
    check("R2 pulldown in test", 32'(weak_pd), 32'h1);
    amp_rst_n = 1; cyc(30);
    check("R4 stuck-low stalls", 32'(ramp_active), 32'h0);
    check("R4 stuck-low hiz", 32'(out_hiz), 32'hF);
    short_lo = 0; short_hi = 4'b0001; cyc(40);
    check("R3 stuck-high phase stalls", 32'(ramp_active), 32'h0);
    short_hi = 0; cyc(20);
    check("R6 ramp after test", 32'(ramp_active), 32'h1);
    cyc(105 * TICK_DIV + 10);
    check("R7 running after ramp", 32'(running), 32'h1);
    short_lo = 4'hF; short_hi = 4'hF; cyc(30);
    check("R5 late short ignored", 32'(running), 32'h1);
    check("R5 late short outputs", 32'(out_hiz), 32'h0);
    short_lo = 0; short_hi = 0;
    amp_rst_n = 0; cyc(5);
    check("R7 shutdown ramp", 32'(ramp_active), 32'h1);
    cyc(105 * TICK_DIV + 10);
    check("R7 hiz after shutdown", 32'(out_hiz), 32'hF);
    ramp_extra = 11'd0; settle_ticks = 4'd15;
    amp_rst_n = 1; cyc(20);
    check("R6 second ramp", 32'(ramp_active), 32'h1);
    vdd_ok = 0; cyc(1);
    check("R8 drop ramp", 32'(ramp_active), 32'h0);
    check("R8 drop hiz", 32'(out_hiz), 32'hF);
    cyc(10); vdd_ok = 1; cyc(5);
    check("R5 test skipped", 32'(ramp_active), 32'h1);
    cyc(100 * TICK_DIV + 10);
    check("R6 base-length ramp done", 32'(running), 32'h1);
    gvdd_ok = 0; cyc(1);
    check("R8 drop running", 32'(running), 32'h0);
    cyc(5);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule